// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block connects a 32-bit register-bus slave port, which sees only a 4 KB offset range, to a 64 KB internal register space. A 6-bit page field in a control register supplies the upper internal offset bits. Bus offsets whose bits [11:10] are both set form a 1 KB paged aperture. An access there is sent to internal offset `{page, offset[9:0]}`. Every other bus offset maps one-to-one onto internal offsets 0x000 to 0xBFF.

The internal space holds a sparse set of word registers. There is a low bank of 32 words at 0x0000 to 0x007F and a high bank of 16 words at 0x4B80 to 0x4BBF. The high bank can be reached only through the aperture. The control register sits at internal 0x0808. It can be reached directly at bus offset 0x808, or through the aperture with page 2 at bus offset 0xC08. Software changes the page with a read-modify-write of the control register, so the two data-path enable bits are kept. The new page applies to the very next access.

Top module: `pcsr_window`

## Requirements
- R1: Reset is synchronous and active high. While reset is asserted and after it is released:
  - the page field is 0;
  - both enable outputs are 0;
  - every bank word is 0;
  - `rsp_valid` is 0.
- R2: The control register is at internal offset 0x0808. Its fields are:
  - bit 0 drives `bus_pio_en`;
  - bit 1 drives `link_pio_en`;
  - bits [18:13] hold the page, which is also shown on `page_sel`.
  All other bits read 0 and are discarded on write.
- R3: A bus offset with bits [11:10] equal to 2'b11 reaches internal offset `{page, offset[9:0]}`.
- R4: A bus offset with bits [11:10] not equal to 2'b11 reaches the same internal offset, zero-extended to 16 bits.
- R5: A register reached directly and the same register reached through the aperture hold the same storage. This includes the control register at 0xC08 with page 2.
- R6: A write that changes the page takes effect for the access in the next cycle.
- R7: Rewriting the page with bits 0 and 1 written back unchanged leaves both enable outputs unchanged.
- R8: An internal offset that hits no register reads as 0, and writes to it change no register.
- R9: A read request gives `rsp_valid` high in the following cycle, with the data on `rsp_rdata`. A write request gives no response.
- R10: Bus offset bits [1:0] are ignored, so every byte offset inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Bus byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bus_pio_en | output | 1 | Control bit 0 |
| link_pio_en | output | 1 | Control bit 1 |
| page_sel | output | 6 | Current page field |

## Verification
A read issued at one rising edge returns its data at the same edge, through one register stage. The bench therefore drives each request on the falling edge and samples `rsp_valid` and `rsp_rdata` 1 ns after the next rising edge. A write takes effect at the edge that accepts it, including a page or enable change. The enable outputs are therefore checked at that same sample point, and the following access already runs against the updated model. Back-to-back accesses, one per cycle, exercise the case where a page write is followed at once by a paged read.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
    localparam int unsigned BUS_AW     = 12;
    localparam int unsigned INT_AW     = 16;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned PAGE_W     = INT_AW - 10;
    localparam int unsigned PAGE_LO_W  = 10;
    localparam int unsigned PAGE_POS   = 13;
    localparam logic [INT_AW-1:0] CTRL_OFS = 16'h0808;

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BANK_BASE  [NUM_BANKS] = '{32'h0000, 32'h4B80};
    localparam int unsigned BANK_WORDS [NUM_BANKS] = '{32, 16};

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              link_pio;
        logic              bus_pio;
    } ctrl_t;

    typedef struct packed {
        logic [INT_AW-1:0] addr;
        logic              paged;
    } xlate_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.bus_pio;
        w[1] = c.link_pio;
        w[PAGE_POS +: PAGE_W] = c.page;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.bus_pio  = w[0];
        c.link_pio = w[1];
        c.page     = w[PAGE_POS +: PAGE_W];
        return c;
    endfunction
endpackage

// File: rtl/pcsr_addr_decode.sv
module pcsr_addr_decode
    import pcsr_pkg::*;
(
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [PAGE_W-1:0] page,
    output xlate_t            xl
);
    always_comb begin
        xl.paged = &bus_addr[BUS_AW-1:BUS_AW-2];
        if (xl.paged)
            xl.addr = {page, bus_addr[PAGE_LO_W-1:0]};
        else
            xl.addr = {{(INT_AW-BUS_AW){1'b0}}, bus_addr};
    end
endmodule

// File: rtl/pcsr_ctrl_reg.sv
module pcsr_ctrl_reg
    import pcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_AW-1:0] int_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl
);
    assign hit   = (int_addr[INT_AW-1:2] == CTRL_OFS[INT_AW-1:2]);
    assign rdata = hit ? ctrl_pack(ctrl) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_en && hit)
            ctrl <= ctrl_unpack(wdata);
    end

    // R1: reset clears every field
    assert_ctrl_reset_R1: assert property (@(posedge clk) rst |=> (ctrl == '0));
    // R7: fields hold when the register is not written
    assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit) |=> $stable(ctrl));
    // R6: a write lands in the next cycle
    assert_ctrl_update_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (ctrl == ctrl_unpack($past(wdata))));
endmodule

// File: rtl/pcsr_reg_bank.sv
module pcsr_reg_bank
    import pcsr_pkg::*;
#(
    parameter int unsigned BASE  = 0,
    parameter int unsigned WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_AW-1:0] int_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WA_W  = INT_AW - 2;
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [WA_W-1:0] BASE_W = WA_W'(BASE >> 2);

    logic [DATA_W-1:0] mem [WORDS];
    logic [WA_W-1:0]   rel;
    logic [IDX_W-1:0]  idx;

    assign rel   = int_addr[INT_AW-1:2] - BASE_W;
    assign hit   = (32'(rel) < WORDS);
    assign idx   = rel[IDX_W-1:0];
    assign rdata = hit ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en && hit) begin
            mem[idx] <= wdata;
        end
    end

    // R8: a missed write leaves the addressed-range contents alone
    assert_bank_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(mem[0]));
endmodule

// File: rtl/pcsr_window.sv
module pcsr_window
    import pcsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BUS_AW-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 bus_pio_en,
    output logic                 link_pio_en,
    output logic [PAGE_W-1:0]    page_sel
);
    ctrl_t             ctrl;
    xlate_t            xl;
    logic              wr_en;
    logic              ctrl_hit;
    logic [DATA_W-1:0] ctrl_rdata;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0] rd_mux;

    assign wr_en       = req_valid && req_write;
    assign bus_pio_en  = ctrl.bus_pio;
    assign link_pio_en = ctrl.link_pio;
    assign page_sel    = ctrl.page;

    pcsr_addr_decode u_dec (
        .bus_addr (req_addr),
        .page     (ctrl.page),
        .xl       (xl)
    );

    pcsr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .int_addr (xl.addr),
        .wr_en    (wr_en),
        .wdata    (req_wdata),
        .hit      (ctrl_hit),
        .rdata    (ctrl_rdata),
        .ctrl     (ctrl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcsr_reg_bank #(
            .BASE  (BANK_BASE[b]),
            .WORDS (BANK_WORDS[b])
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .int_addr (xl.addr),
            .wr_en    (wr_en),
            .wdata    (req_wdata),
            .hit      (bank_hit[b]),
            .rdata    (bank_rdata[b])
        );
    end

    always_comb begin
        rd_mux = ctrl_rdata;
        for (int b = 0; b < NUM_BANKS; b++) rd_mux = rd_mux | bank_rdata[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_mux;
        end
    end

    // R5: an internal offset selects at most one target
    assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bank_hit, ctrl_hit}));
    // R3: paged translation carries the current page
    assert_paged_page_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && xl.paged) |-> (xl.addr[INT_AW-1:PAGE_LO_W] == page_sel));
    // R4: direct translation stays below 0xC00
    assert_direct_range_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xl.paged) |-> (xl.addr < 16'h0C00));
    // R9: read responses follow reads only
    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    assert_no_wr_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
    // R8: a read that hits nothing returns zero
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !ctrl_hit && bank_hit == '0) |=> (rsp_rdata == '0));
endmodule

// File: tb/test_pcsr_window.sv
module test_pcsr_window;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_pio_en, link_pio_en;
    logic [5:0]  page_sel;

    int checks = 0;
    int errors = 0;

    logic [5:0]  m_page = '0;
    logic        m_bpio = 1'b0, m_lpio = 1'b0;
    logic [31:0] m_lo [32];
    logic [31:0] m_hi [16];

    always #2 clk = ~clk;

    pcsr_window i_pcsr_window (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bus_pio_en(bus_pio_en),
        .link_pio_en(link_pio_en), .page_sel(page_sel)
    );

    function automatic logic [15:0] eff(logic [11:0] a);
        return (a[11:10] == 2'b11) ? {m_page, a[9:0]} : {4'h0, a};
    endfunction

    function automatic logic [31:0] ctrl_word();
        logic [31:0] w = '0;
        w[0] = m_bpio; w[1] = m_lpio; w[18:13] = m_page;
        return w;
    endfunction

    function automatic logic [31:0] model_rd(logic [11:0] a);
        logic [15:0] e = eff(a);
        if (e[15:2] == 14'h0202) return ctrl_word();
        if (e < 16'h0080) return m_lo[e[6:2]];
        if (e >= 16'h4B80 && e < 16'h4BC0) return m_hi[e[5:2]];
        return 32'h0;
    endfunction

    function automatic void model_wr(logic [11:0] a, logic [31:0] d);
        logic [15:0] e = eff(a);
        if (e[15:2] == 14'h0202) begin
            m_bpio = d[0]; m_lpio = d[1]; m_page = d[18:13];
        end else if (e < 16'h0080) m_lo[e[6:2]] = d;
        else if (e >= 16'h4B80 && e < 16'h4BC0) m_hi[e[5:2]] = d;
    endfunction

    function automatic string tag_of(logic [11:0] a);
        logic [15:0] e = eff(a);
        if (e[15:2] == 14'h0202) return "R2";
        if (e < 16'h0080 || (e >= 16'h4B80 && e < 16'h4BC0))
            return (a[11:10] == 2'b11) ? "R3" : "R4";
        return "R8";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        model_wr(a, d);
        check("R9", {31'b0, rsp_valid}, 32'h0);
        check("R2", {29'b0, page_sel == m_page, link_pio_en, bus_pio_en},
              {29'b0, 1'b1, m_lpio, m_bpio});
    endtask

    task automatic rd(logic [11:0] a, string req);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        exp = model_rd(a);
        @(posedge clk); #1;
        check("R9", {31'b0, rsp_valid}, 32'h1);
        check(req, rsp_rdata, exp);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 32; i++) m_lo[i] = '0;
        for (int i = 0; i < 16; i++) m_hi[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state while reset is held
        check("R1", {31'b0, rsp_valid}, 32'h0);
        check("R1", {24'b0, page_sel, link_pio_en, bus_pio_en}, 32'h0);
        @(negedge clk); rst = 1'b0;
        rd(12'h000, "R1");
        rd(12'h07C, "R1");

        // R2 field layout, reserved bits dropped
        wr(12'h808, 32'hFFFF_FFFF);
        rd(12'h808, "R2");
        check("R2", rsp_rdata, 32'h0007_E003);
        // R7 rewrite page keeping enable bits
        wr(12'h808, 32'h0000_4003);
        check("R7", {30'b0, link_pio_en, bus_pio_en}, 32'h3);
        check("R7", {26'b0, page_sel}, 32'h2);
        // R5 control reachable through aperture with page 2
        rd(12'hC08, "R5");
        check("R5", rsp_rdata, 32'h0000_4003);
        // R5 direct write, paged read (page 0)
        wr(12'h808, 32'h0000_0003);
        wr(12'h010, 32'hA5A5_1234);
        rd(12'hC10, "R5");
        check("R5", rsp_rdata, 32'hA5A5_1234);
        // R10 low address bits ignored
        rd(12'h013, "R10");
        check("R10", rsp_rdata, 32'hA5A5_1234);
        // R6 page change used by the very next access; high bank only via page 0x12
        wr(12'h808, {13'b0, 6'h12, 11'b0, 2'b11});
        wr(12'hF84, 32'hDEAD_BEEF);
        rd(12'hF84, "R6");
        check("R3", rsp_rdata, 32'hDEAD_BEEF);
        // R8 unmapped write then read
        wr(12'h808, {13'b0, 6'h3F, 11'b0, 2'b11});
        wr(12'hC40, 32'h1111_2222);
        rd(12'hC40, "R8");
        check("R8", rsp_rdata, 32'h0);
        wr(12'h400, 32'h3333_4444);
        rd(12'h400, "R8");
        rd(12'h010, "R8");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            int unsigned k = $urandom_range(0, 9);
            d = $urandom();
            case (k)
                0: a = {5'b0, 7'($urandom_range(0, 127))};
                1: a = 12'hC00 | 12'($urandom_range(0, 127));
                2: a = 12'hF80 | 12'($urandom_range(0, 63));
                3: a = 12'h808 | 12'($urandom_range(0, 3));
                4: a = 12'hC08;
                5: a = 12'($urandom_range(0, 4095));
                default: a = 12'($urandom_range(0, 4095)) & 12'hC7F;
            endcase
            if (k == 3 && $urandom_range(0, 1) == 1) begin
                logic [5:0] pg;
                case ($urandom_range(0, 3))
                    0: pg = 6'h00;
                    1: pg = 6'h02;
                    2: pg = 6'h12;
                    default: pg = 6'($urandom());
                endcase
                wr(a, {13'b0, pg, 11'b0, 2'($urandom())});
            end else if ($urandom_range(0, 2) == 0) begin
                if (eff(a)[15:2] != 14'h0202) wr(a, d);
            end else begin
                rd(a, tag_of(a));
            end
        end
        idle();
        @(posedge clk); #1;
        check("R9", {31'b0, rsp_valid}, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule